// File: doc/BRIEF.md
# Microcode RAM Byte Loader

This block lets a host fill and inspect a 32-bit-wide instruction memory through a register interface that is only one byte wide. The host turns on loading with a control bit and programs a 9-bit start word address through a low address byte and a one-bit high address register. It then writes bytes to a single data window. Each group of four writes becomes one instruction word, least significant byte first. The word goes into memory on the fourth write, and the word address then moves on by one.

Reads from the same window return the bytes of the addressed word in order and move the address forward in the same way. A second control bit sends the address and the byte position back to zero, so the host can start over at word 0. A write to either address register puts the byte position back to zero, so a new address always starts at byte 0.

Top module: `ucode_byte_loader`

## Requirements
- R1: After reset the control register reads 0x00 and both address registers read 0x00.
- R2: Data-window writes are packed least significant byte first. The word is written to memory only on the fourth write, so three writes followed by an address write leave the stored word unchanged.
- R3: The word address holds through byte positions 0 to 2 and goes up by one only after the access at byte position 3.
- R4: Register select 2 is the low address byte, which holds address bits 7:0. Register select 3 holds address bit 8 in its bit 0; its other bits read back as 0.
- R5: Control bit 0 (register select 0) enables loading. While it is clear, data-window writes have no effect on memory, the address or the byte position. Reads still work.
- R6: Writing 1 to control bit 1 sets the word address and the byte position to zero. The bit reads back as 0.
- R7: Any write to an address register sets the byte position to zero.
- R8: Data-window reads (register select 1) return bytes 0, 1, 2 and 3 of the addressed word in turn and advance the address as writes do.
- R9: The word address wraps from 511 to 0.
- R10: rdata_o shows the read value in the cycle after the read request. It keeps that value until the next read, and writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 2 | Register select: 0 control, 1 data window, 2 address low, 3 address high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
Every register write, including the memory commit on the fourth byte, takes effect at the clock edge that samples the request. Read data appears on rdata_o one edge after the read request. The bench drives each access at a falling edge and updates its reference model at the following rising edge. It compares rdata_o with the model at every falling edge, half a cycle after the register has settled. Directed checks of address advance, wrap and ignored writes read the address registers back through the port. Each such value is therefore seen exactly one cycle after the read that fetched it.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_DATA    = 2'd1,
    SEL_ADDR_LO = 2'd2,
    SEL_ADDR_HI = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_LOAD_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT  = 1;
endpackage

// File: rtl/ucode_addr_ctr.sv
module ucode_addr_ctr #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned IDX_W     = $clog2(WORD_BYTES),
  localparam int unsigned HI_W      = ADDR_W - ucode_pkg::BYTE_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       lo_we_i,
  input  logic                       hi_we_i,
  input  logic [ucode_pkg::BYTE_W-1:0] wdata_i,
  input  logic                       step_i,
  output logic [ADDR_W-1:0]          word_addr_o,
  output logic [IDX_W-1:0]           byte_idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (clr_i) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (lo_we_i) begin
      addr_q[ucode_pkg::BYTE_W-1:0] <= wdata_i;
      idx_q <= '0;
    end else if (hi_we_i) begin
      addr_q[ADDR_W-1:ucode_pkg::BYTE_W] <= wdata_i[HI_W-1:0];
      idx_q <= '0;
    end else if (step_i) begin
      if (idx_q == LAST_IDX) begin
        idx_q  <= '0;
        addr_q <= addr_q + 1'b1;  // natural wrap at the top of memory
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign word_addr_o = addr_q;
  assign byte_idx_o  = idx_q;
endmodule

// File: rtl/ucode_word_asm.sv
module ucode_word_asm #(
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned IDX_W     = $clog2(WORD_BYTES),
  localparam int unsigned WORD_W    = WORD_BYTES * ucode_pkg::BYTE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         byte_we_i,
  input  logic [IDX_W-1:0]             byte_idx_i,
  input  logic [ucode_pkg::BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0]            word_o,
  output logic                         commit_o
);
  localparam int unsigned BW = ucode_pkg::BYTE_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

  // lower bytes are staged; the top byte comes straight from the bus
  for (genvar b = 0; b < WORD_BYTES - 1; b++) begin : g_stage
    logic [BW-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        byte_q <= '0;
      else if (byte_we_i && byte_idx_i == IDX_W'(b))
        byte_q <= byte_i;
    end
    assign word_o[b*BW +: BW] = byte_q;
  end

  assign word_o[WORD_W-1 -: BW] = byte_i;
  assign commit_o = byte_we_i && (byte_idx_i == LAST_IDX);
endmodule

// File: rtl/ucode_ram.sv
module ucode_ram #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned IDX_W     = $clog2(WORD_BYTES),
  localparam int unsigned WORD_W    = WORD_BYTES * ucode_pkg::BYTE_W,
  localparam int unsigned DEPTH     = 1 << ADDR_W
) (
  input  logic                         clk_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  input  logic [IDX_W-1:0]             byte_sel_i,
  output logic [ucode_pkg::BYTE_W-1:0] rbyte_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rword;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rword   = mem[addr_i];
  assign rbyte_o = rword[byte_sel_i*ucode_pkg::BYTE_W +: ucode_pkg::BYTE_W];
endmodule

// File: rtl/ucode_byte_loader.sv
module ucode_byte_loader #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] sel_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  import ucode_pkg::*;

  localparam int unsigned IDX_W  = $clog2(WORD_BYTES);
  localparam int unsigned WORD_W = WORD_BYTES * BYTE_W;
  localparam int unsigned HI_W   = ADDR_W - BYTE_W;

  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  logic load_en;
  logic wr, rd, clr, lo_we, hi_we, data_wr, data_rd, step;
  logic [ADDR_W-1:0] word_addr;
  logic [IDX_W-1:0]  byte_idx;
  logic [WORD_W-1:0] asm_word;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_byte;
  logic [BYTE_W-1:0] rd_mux;
  logic [BYTE_W-1:0] rdata_q;

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign clr     = wr && (sel == SEL_CTRL) && wdata_i[CTRL_CLR_BIT];
  assign lo_we   = wr && (sel == SEL_ADDR_LO);
  assign hi_we   = wr && (sel == SEL_ADDR_HI);
  assign data_wr = wr && (sel == SEL_DATA) && load_en;
  assign data_rd = rd && (sel == SEL_DATA);
  assign step    = data_wr || data_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      load_en <= 1'b0;
    else if (wr && sel == SEL_CTRL)
      load_en <= wdata_i[CTRL_LOAD_BIT];
  end

  ucode_addr_ctr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .lo_we_i     (lo_we),
    .hi_we_i     (hi_we),
    .wdata_i     (wdata_i),
    .step_i      (step),
    .word_addr_o (word_addr),
    .byte_idx_o  (byte_idx)
  );

  ucode_word_asm #(.WORD_BYTES(WORD_BYTES)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_we_i  (data_wr),
    .byte_idx_i (byte_idx),
    .byte_i     (wdata_i),
    .word_o     (asm_word),
    .commit_o   (mem_we)
  );

  ucode_ram #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_ram (
    .clk_i      (clk_i),
    .we_i       (mem_we),
    .addr_i     (word_addr),
    .wdata_i    (asm_word),
    .byte_sel_i (byte_idx),
    .rbyte_o    (mem_byte)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL:    rd_mux[CTRL_LOAD_BIT] = load_en;
      SEL_DATA:    rd_mux = mem_byte;
      SEL_ADDR_LO: rd_mux = word_addr[BYTE_W-1:0];
      SEL_ADDR_HI: rd_mux[HI_W-1:0] = word_addr[ADDR_W-1:BYTE_W];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ucode_byte_loader_chk.sv
module ucode_byte_loader_chk #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned IDX_W     = $clog2(WORD_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        sel_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              load_en,
  input logic [ADDR_W-1:0] word_addr,
  input logic [IDX_W-1:0]  byte_idx,
  input logic              mem_we
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

  logic data_acc, wr_ctrl, wr_addr;
  assign data_acc = req_i && sel_i == 2'd1 && (!we_i || load_en);
  assign wr_ctrl  = req_i && we_i && sel_i == 2'd0;
  assign wr_addr  = req_i && we_i && sel_i[1];

  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && byte_idx != LAST_IDX |=> $stable(word_addr));

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && byte_idx == LAST_IDX && word_addr != '1 |=>
      word_addr == $past(word_addr) + 1'b1);

  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && byte_idx == LAST_IDX && word_addr == '1 |=> word_addr == '0);

  a_r5_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && sel_i == 2'd1 && !load_en |=>
      $stable(word_addr) && $stable(byte_idx));

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && wdata_i[1] |=> word_addr == '0 && byte_idx == '0);

  a_r7_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr |=> byte_idx == '0);

  a_r2_commit_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> byte_idx == LAST_IDX && load_en && req_i && we_i);

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

bind ucode_byte_loader ucode_byte_loader_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .sel_i     (sel_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .load_en   (load_en),
  .word_addr (word_addr),
  .byte_idx  (byte_idx),
  .mem_we    (mem_we)
);

// File: tb/ucode_byte_loader_bench.sv
`timescale 1ns/1ps
module ucode_byte_loader_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] sel_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;

  ucode_byte_loader u_ucode_byte_loader (
    .clk_i, .rst_ni, .req_i, .we_i, .sel_i, .wdata_i, .rdata_o
  );

  // behavioural reference model
  int unsigned m_addr, m_idx;
  bit          m_en;
  logic [31:0] m_mem [int];
  byte unsigned m_buf [4];
  logic [7:0]  m_rdata;

  task automatic m_adv();
    if (m_idx == 3) begin m_idx = 0; m_addr = (m_addr + 1) % 512; end
    else m_idx++;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_addr = 0; m_idx = 0; m_en = 0; m_rdata = 8'h00;
    end else if (req_i) begin
      case (sel_i)
        2'd0: if (we_i) begin
                m_en = wdata_i[0];
                if (wdata_i[1]) begin m_addr = 0; m_idx = 0; end
              end else m_rdata = {7'd0, m_en};
        2'd1: if (we_i) begin
                if (m_en) begin
                  m_buf[m_idx] = wdata_i;
                  if (m_idx == 3) m_mem[m_addr] = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
                  m_adv();
                end
              end else begin
                m_rdata = m_mem.exists(m_addr) ? 8'(m_mem[m_addr] >> (8*m_idx)) : 8'h00;
                m_adv();
              end
        2'd2: if (we_i) begin m_addr = (m_addr & 'h100) | wdata_i; m_idx = 0; end
              else m_rdata = 8'(m_addr);
        default: if (we_i) begin m_addr = (m_addr & 'hff) | (32'(wdata_i[0]) << 8); m_idx = 0; end
              else m_rdata = 8'(m_addr >> 8);
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (rdata_o !== m_rdata) begin
        errors++;
        $display("FAIL %s model compare: rdata_o=%02h expected %02h", cur_req, rdata_o, m_rdata);
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic acc(bit we, logic [1:0] sel, logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; sel_i = sel; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d); acc(1'b1, sel, d); endtask

  task automatic rd(logic [1:0] sel, output logic [7:0] v);
    acc(1'b0, sel, 8'h00);
    v = rdata_o;
  endtask

  task automatic rd_chk(string req, logic [1:0] sel, logic [7:0] exp);
    logic [7:0] v;
    cur_req = req;
    rd(sel, v);
    chk(req, v, exp);
  endtask

  task automatic wr_word(logic [31:0] w);
    for (int b = 0; b < 4; b++) wr(2'd1, w[8*b +: 8]);
  endtask

  task automatic rd_word_chk(string req, logic [31:0] w);
    for (int b = 0; b < 4; b++) rd_chk(req, 2'd1, w[8*b +: 8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd_chk("R1", 2'd0, 8'h00);
    rd_chk("R1", 2'd2, 8'h00);
    rd_chk("R1", 2'd3, 8'h00);
    // R4 address registers
    cur_req = "R4";
    wr(2'd0, 8'h01);
    wr(2'd2, 8'hFE);
    wr(2'd3, 8'h03);
    rd_chk("R4", 2'd3, 8'h01);
    rd_chk("R4", 2'd2, 8'hFE);
    // R3 address holds mid-word
    cur_req = "R3";
    wr(2'd1, 8'h44); wr(2'd1, 8'h33);
    rd_chk("R3", 2'd2, 8'hFE);
    wr(2'd1, 8'h22); wr(2'd1, 8'h11);
    rd_chk("R3", 2'd2, 8'hFF);
    rd_chk("R3", 2'd3, 8'h01);
    // R9 wrap
    cur_req = "R9";
    wr_word(32'h55667788);
    rd_chk("R9", 2'd2, 8'h00);
    rd_chk("R9", 2'd3, 8'h00);
    wr_word(32'hAABBCCDD);
    // R2 commit only on fourth byte
    cur_req = "R2";
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h99); wr(2'd1, 8'h99); wr(2'd1, 8'h99);
    wr(2'd2, 8'h00);
    rd_word_chk("R2", 32'hAABBCCDD);
    // R7 byte position reset by address write
    cur_req = "R7";
    wr(2'd1, 8'hEE); wr(2'd1, 8'hEE);
    wr(2'd2, 8'h00);
    wr_word(32'h04030201);
    wr(2'd2, 8'h00);
    rd_word_chk("R7", 32'h04030201);
    // R8 read advance
    rd_chk("R8", 2'd2, 8'h01);
    // R6 control clear
    cur_req = "R6";
    wr(2'd2, 8'h05);
    wr(2'd1, 8'h55); wr(2'd1, 8'h55);
    wr(2'd0, 8'h03);
    rd_chk("R6", 2'd0, 8'h01);
    rd_chk("R6", 2'd2, 8'h00);
    rd_chk("R6", 2'd3, 8'h00);
    wr_word(32'hF3F2F1F0);
    wr(2'd2, 8'h00);
    rd_word_chk("R6", 32'hF3F2F1F0);
    // R8 and R9 through reads
    cur_req = "R8";
    wr(2'd3, 8'h01);
    wr(2'd2, 8'hFE);
    rd_word_chk("R8", 32'h11223344);
    rd_word_chk("R8", 32'h55667788);
    rd_chk("R9", 2'd2, 8'h00);
    rd_chk("R9", 2'd3, 8'h00);
    // R5 writes ignored while load disabled
    cur_req = "R5";
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h01);
    wr(2'd2, 8'hFF);
    wr_word(32'h78563412);
    rd_chk("R5", 2'd2, 8'hFF);
    rd_chk("R5", 2'd0, 8'h00);
    wr(2'd2, 8'hFF);
    rd_word_chk("R5", 32'h55667788);
    // R10 hold across idle cycles and writes
    cur_req = "R10";
    repeat (5) @(negedge clk_i);
    chk("R10", rdata_o, 8'h55);
    wr(2'd2, 8'h10);
    chk("R10", rdata_o, 8'h55);
    rd_chk("R10", 2'd2, 8'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule